// File: doc/BRIEF.md
# Set-Sampled Way-Utility Hit Monitor

This block estimates how many extra off-chip misses a set-associative cache would take if some of its ways held tags but no data. It watches the cache access stream and keeps an auxiliary tag directory for only a sample of the sets: those whose five lowest index bits are all zero, which is one set in thirty-two. Each sampled set holds as many tags as the main cache has ways, kept in recency order. Every access that hits in the directory reports the recency position where it hit.

One hit counter exists per recency position. A counter advances only when the request needed data stored in this cache, such as a read of a shared line. A hit that would be forwarded to a private cache holding the line exclusively is not counted, because a way without data could have served it just as well. At the end of each measurement period a pulse copies the counters into output registers and clears them. Removing data from k ways is modelled as losing the k least-recently-used positions. The block therefore also gives the sum of the snapshot counters for the k deepest positions, which is the miss estimate the way-selection logic needs.

Top module: `way_utility_monitor`

## Requirements
- R1: After reset every snapshot count reads 0, `loss_est` is 0 for every `loss_ways`, and every directory entry is empty.
- R2: An access is sampled only when `acc_set[4:0]` is all zero. An access to any other set changes neither a counter nor any directory entry.
- R3: Each sampled set keeps WAYS tags in recency order, position 0 most recent and WAYS-1 least recent. A tag is held at most once per set. A hit at position p moves that tag to position 0 and shifts positions 0..p-1 down by one.
- R4: A sampled miss inserts the tag at position 0 and shifts all positions down by one. Empty entries are filled first; after that, the tag at position WAYS-1 is evicted. A miss changes no counter.
- R5: A sampled hit with `acc_needs_data`=1 adds one to the counter of the position where the tag was found, taken before the move.
- R6: A sampled hit with `acc_needs_data`=0 updates recency as in R3 but changes no counter.
- R7: Each counter saturates at 2^CNT_W-1. Further counted hits leave it at that value.
- R8: On `period_end` each live counter is copied to its snapshot register and then cleared. A counted hit in the same cycle becomes the first count of the new period. Snapshot registers change only on `period_end`.
- R9: `rd_count` shows the snapshot of position `rd_pos` combinationally.
- R10: `loss_est` equals the sum of the snapshots for positions WAYS-k..WAYS-1, where k=`loss_ways`. k=0 gives 0, and any k of WAYS or more sums all positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | SET_BITS | Set index of the access |
| acc_tag | input | TAG_BITS | Tag of the access |
| acc_needs_data | input | 1 | 1: request needed data held in this cache; 0: served by an exclusive owner |
| period_end | input | 1 | End of measurement period: snapshot and clear |
| rd_pos | input | clog2(WAYS) | Recency position to read |
| rd_count | output | CNT_W | Snapshot count of position `rd_pos` |
| loss_ways | input | clog2(WAYS+1) | Number of ways assumed to lose their data |
| loss_est | output | CNT_W+clog2(WAYS+1) | Estimated extra misses for `loss_ways` data-less ways |
| snap_counts | output | WAYS*CNT_W | All snapshot counts, position p in bits [p*CNT_W +: CNT_W] |

## Verification
The assertions check on every cycle several properties that hold at all times. At most one directory entry matches an access, so no tag is held twice in a set. Accesses to unsampled sets and hits served by an exclusive owner never move a live counter. A counter at its maximum stays there. The live counters clear on a period end, and the snapshots stay still between period ends. Other behaviour can only be shown by the bench's directed sequences, because it depends on a history of accesses: the exact recency position reported after fills, evictions and reorderings, the eviction of the least-recent tag, the fact that a non-counted hit still reorders recency, a hit that coincides with a period end, and the suffix sums for each number of lost ways.

// File: rtl/wum_pkg.sv
// Shared types for the way-utility monitor.
// Assumes nothing beyond the IEEE 1800-2017 language.
package wum_pkg;

    // Outcome of an auxiliary-directory lookup for one access.
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,   // no sampled access this cycle
        LK_HIT  = 2'd1,   // tag found in the sampled set
        LK_MISS = 2'd2    // tag absent, inserted at the most-recent slot
    } lookup_e;

endpackage

// File: rtl/wum_tag_stack.sv
// Auxiliary tag directory for the sampled sets.
// Each sampled set is a recency stack of WAYS entries, with slot 0 the
// most recent. A lookup compares all slots of the row in the access cycle.
// The row is rewritten at the same clock edge, so back-to-back accesses to
// one set see each other's updates.
// Assumes SET_BITS > SAMPLE_LOG2 and that empty slots sit below valid ones.
module wum_tag_stack
    import wum_pkg::*;
#(
    parameter int WAYS        = 8,
    parameter int SET_BITS    = 10,
    parameter int TAG_BITS    = 16,
    parameter int SAMPLE_LOG2 = 5,
    localparam int POS_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int ROW_W      = SET_BITS - SAMPLE_LOG2,
    localparam int ROWS       = 1 << ROW_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [SET_BITS-1:0] acc_set,
    input  logic [TAG_BITS-1:0] acc_tag,
    output lookup_e             lk,
    output logic [POS_W-1:0]    hit_pos,
    output logic [WAYS-1:0]     hit_vec
);

    logic [TAG_BITS-1:0] tag_q [ROWS][WAYS];
    logic [WAYS-1:0]     vld_q [ROWS];

    logic                sampled;
    logic [ROW_W-1:0]    row;
    logic                any_hit;
    logic [POS_W-1:0]    shift_lim;

    // Decide whether the access falls in a sampled set and which row it uses.
    always_comb begin
        sampled = acc_valid && (acc_set[SAMPLE_LOG2-1:0] == '0);
        row     = acc_set[SET_BITS-1:SAMPLE_LOG2];
    end

    // Compare the access tag against every slot of the selected row.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = sampled && vld_q[row][w] && (tag_q[row][w] == acc_tag);
    end

    // Encode the matching slot and classify the lookup.
    always_comb begin
        hit_pos = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_pos = POS_W'(w);
        end
        any_hit   = |hit_vec;
        shift_lim = any_hit ? hit_pos : POS_W'(WAYS - 1);
        if (!sampled)     lk = LK_IDLE;
        else if (any_hit) lk = LK_HIT;
        else              lk = LK_MISS;
    end

    // Valid bits: cleared on reset, shifted with the tags on each sampled access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) vld_q[r] <= '0;
        end else if (sampled) begin
            for (int w = WAYS - 1; w >= 1; w--) begin
                if (POS_W'(w) <= shift_lim) vld_q[row][w] <= vld_q[row][w-1];
            end
            vld_q[row][0] <= 1'b1;
        end
    end

    // Tags: move slots above the hit (or the whole row on a miss) down, insert at slot 0.
    always_ff @(posedge clk) begin
        if (sampled) begin
            for (int w = WAYS - 1; w >= 1; w--) begin
                if (POS_W'(w) <= shift_lim) tag_q[row][w] <= tag_q[row][w-1];
            end
            tag_q[row][0] <= acc_tag;
        end
    end

endmodule

// File: rtl/wum_pos_counters.sv
// One saturating hit counter per recency position, plus snapshot registers.
// On period_end each live count is copied to its snapshot and cleared. An
// increment in that same cycle starts the new period at one.
// Assumes at most one increment per cycle (inc_en with a single position).
module wum_pos_counters #(
    parameter int WAYS  = 8,
    parameter int CNT_W = 24,
    localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_en,
    input  logic [POS_W-1:0]      inc_pos,
    input  logic                  period_end,
    output logic [WAYS*CNT_W-1:0] live_flat,
    output logic [WAYS*CNT_W-1:0] snap_flat
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar p = 0; p < WAYS; p++) begin : g_pos
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] snap_q;
        logic             bump;

        // Select whether this position receives the current counted hit.
        assign bump = inc_en && (inc_pos == POS_W'(p));

        // Live counter: restart on period end, otherwise count up to saturation.
        always_ff @(posedge clk) begin
            if (!rst_n)               cnt_q <= '0;
            else if (period_end)      cnt_q <= bump ? CNT_W'(1) : '0;
            else if (bump && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        end

        // Snapshot register: captures the live count at each period end.
        always_ff @(posedge clk) begin
            if (!rst_n)          snap_q <= '0;
            else if (period_end) snap_q <= cnt_q;
        end

        assign live_flat[p*CNT_W +: CNT_W] = cnt_q;
        assign snap_flat[p*CNT_W +: CNT_W] = snap_q;
    end

endmodule

// File: rtl/wum_loss_sum.sv
// Sums the snapshot counts of the k least-recent positions. That sum is the
// miss estimate for k data-less ways. Purely combinational; k >= WAYS sums
// every position.
module wum_loss_sum #(
    parameter int WAYS  = 8,
    parameter int CNT_W = 24,
    localparam int K_W   = $clog2(WAYS + 1),
    localparam int EST_W = CNT_W + K_W
) (
    input  logic [WAYS*CNT_W-1:0] snap_flat,
    input  logic [K_W-1:0]        loss_ways,
    output logic [EST_W-1:0]      loss_est
);

    // Accumulate the suffix of positions WAYS-k .. WAYS-1.
    always_comb begin
        loss_est = '0;
        for (int p = 0; p < WAYS; p++) begin
            if (p >= WAYS - int'(loss_ways)) begin
                loss_est = loss_est + EST_W'(snap_flat[p*CNT_W +: CNT_W]);
            end
        end
    end

endmodule

// File: rtl/way_utility_monitor.sv
// Set-sampled way-utility hit monitor.
// Tracks recency positions of hits in a sampled auxiliary tag directory. It
// counts only hits that need data held in this cache, snapshots the counts
// per period, and gives the extra-miss estimate for a chosen number of
// data-less ways.
// Assumes one access per cycle and a synchronous active-low reset.
module way_utility_monitor
    import wum_pkg::*;
#(
    parameter int WAYS        = 8,
    parameter int SET_BITS    = 10,
    parameter int TAG_BITS    = 16,
    parameter int SAMPLE_LOG2 = 5,
    parameter int CNT_W       = 24,
    localparam int POS_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int K_W        = $clog2(WAYS + 1),
    localparam int EST_W      = CNT_W + K_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [SET_BITS-1:0]   acc_set,
    input  logic [TAG_BITS-1:0]   acc_tag,
    input  logic                  acc_needs_data,
    input  logic                  period_end,
    input  logic [POS_W-1:0]      rd_pos,
    output logic [CNT_W-1:0]      rd_count,
    input  logic [K_W-1:0]        loss_ways,
    output logic [EST_W-1:0]      loss_est,
    output logic [WAYS*CNT_W-1:0] snap_counts
);

    lookup_e               lk;
    logic [POS_W-1:0]      hit_pos;
    logic [WAYS-1:0]       hit_vec;
    logic                  inc_en;
    logic [WAYS*CNT_W-1:0] live_flat;
    logic [WAYS*CNT_W-1:0] snap_flat;

    wum_tag_stack #(
        .WAYS(WAYS), .SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS), .SAMPLE_LOG2(SAMPLE_LOG2)
    ) u_dir (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_tag(acc_tag), .lk(lk), .hit_pos(hit_pos), .hit_vec(hit_vec)
    );

    // Count only hits whose request needed data stored in this cache.
    assign inc_en = (lk == LK_HIT) && acc_needs_data;

    wum_pos_counters #(.WAYS(WAYS), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .inc_pos(hit_pos),
        .period_end(period_end), .live_flat(live_flat), .snap_flat(snap_flat)
    );

    wum_loss_sum #(.WAYS(WAYS), .CNT_W(CNT_W)) u_sum (
        .snap_flat(snap_flat), .loss_ways(loss_ways), .loss_est(loss_est)
    );

    // Read port: select one snapshot count by recency position.
    always_comb begin
        rd_count = '0;
        for (int p = 0; p < WAYS; p++) begin
            if (rd_pos == POS_W'(p)) rd_count = snap_flat[p*CNT_W +: CNT_W];
        end
    end

    assign snap_counts = snap_flat;

endmodule

// File: rtl/way_utility_monitor_chk.sv
// Property checker for way_utility_monitor, attached by bind.
// Watches the directory match vector and the live and snapshot counters.
module way_utility_monitor_chk #(
    parameter int WAYS        = 8,
    parameter int SET_BITS    = 10,
    parameter int SAMPLE_LOG2 = 5,
    parameter int CNT_W       = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_valid,
    input logic [SET_BITS-1:0]   acc_set,
    input logic                  acc_needs_data,
    input logic                  period_end,
    input logic [WAYS-1:0]       hit_vec,
    input logic [WAYS*CNT_W-1:0] live_flat,
    input logic [WAYS*CNT_W-1:0] snap_flat
);

    logic unsampled;
    assign unsampled = acc_valid && (acc_set[SAMPLE_LOG2-1:0] != '0);

    // R3: a tag is never held twice in one set
    assert_unique_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R2: unsampled sets leave the live counters alone
    assert_unsampled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (unsampled && !period_end) |=> $stable(live_flat));

    // R6: owner-served requests leave the live counters alone
    assert_owner_not_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_needs_data && !period_end) |=> $stable(live_flat));

    // R8: a period end with no access leaves all live counters at zero
    assert_period_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !acc_valid) |=> (live_flat == '0));

    // R8: snapshots hold between period ends
    assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(snap_flat));

    // R7: a counter at its maximum stays there until the period ends
    for (genvar p = 0; p < WAYS; p++) begin : g_sat
        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!period_end && (live_flat[p*CNT_W +: CNT_W] == '1))
            |=> (live_flat[p*CNT_W +: CNT_W] == '1));
    end

endmodule

bind way_utility_monitor way_utility_monitor_chk #(
    .WAYS(WAYS), .SET_BITS(SET_BITS), .SAMPLE_LOG2(SAMPLE_LOG2), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_needs_data(acc_needs_data), .period_end(period_end), .hit_vec(hit_vec),
    .live_flat(live_flat), .snap_flat(snap_flat)
);

// File: tb/test_way_utility_monitor.sv
`timescale 1ns/1ps
// Directed bench for way_utility_monitor: one task per scenario.
module test_way_utility_monitor;

    localparam int WAYS = 8, SET_BITS = 10, TAG_BITS = 16, CNT_W = 5;
    localparam int POS_W = 3, K_W = 4, EST_W = CNT_W + K_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_needs_data = 1'b0, period_end = 1'b0;
    logic [SET_BITS-1:0] acc_set = '0;
    logic [TAG_BITS-1:0] acc_tag = '0;
    logic [POS_W-1:0] rd_pos = '0;
    logic [CNT_W-1:0] rd_count;
    logic [K_W-1:0] loss_ways = '0;
    logic [EST_W-1:0] loss_est;
    logic [WAYS*CNT_W-1:0] snap_counts;

    int n_checks = 0, n_fails = 0;

    always #2 clk = ~clk;

    way_utility_monitor #(.WAYS(WAYS), .SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS),
                          .SAMPLE_LOG2(5), .CNT_W(CNT_W)) i_way_utility_monitor (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_tag(acc_tag), .acc_needs_data(acc_needs_data), .period_end(period_end),
        .rd_pos(rd_pos), .rd_count(rd_count), .loss_ways(loss_ways),
        .loss_est(loss_est), .snap_counts(snap_counts)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one access for one cycle.
    task automatic acc(input int set, input int tag, input bit nd);
        acc_valid = 1'b1; acc_set = SET_BITS'(set); acc_tag = TAG_BITS'(tag);
        acc_needs_data = nd;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic pulse();
        period_end = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
    endtask

    // Compare every snapshot through the read port and the flat vector.
    task automatic chk_snap(input int e[WAYS], input string req);
        for (int p = 0; p < WAYS; p++) begin
            rd_pos = POS_W'(p);
            #1;
            check($sformatf("%s R9 rd_pos=%0d", req, p), int'(rd_count), e[p]);
            check($sformatf("%s flat pos=%0d", req, p),
                  int'(snap_counts[p*CNT_W +: CNT_W]), e[p]);
        end
    endtask

    task automatic chk_est(input int k, input int exp);
        loss_ways = K_W'(k);
        #1;
        check($sformatf("R10 k=%0d", k), int'(loss_est), exp);
    endtask

    task automatic t_reset();
        chk_snap('{0,0,0,0,0,0,0,0}, "R1 reset");
        chk_est(8, 0);
    endtask

    // R3/R5: fill set 0, hit at LRU and MRU positions.
    task automatic t_recency();
        for (int i = 0; i < 8; i++) acc(0, 'hA000 + i, 1'b1);
        acc(0, 'hA000, 1'b1);   // position 7
        acc(0, 'hA000, 1'b1);   // position 0
        acc(0, 'hA001, 1'b1);   // position 7
        pulse();
        chk_snap('{1,0,0,0,0,0,0,2}, "R3 R5 recency");
        chk_est(0, 0);
        chk_est(1, 2);
        chk_est(7, 2);
        chk_est(8, 3);
        chk_est(9, 3);
    endtask

    // R4: overflow a set, evicted tags miss without counting.
    task automatic t_evict();
        for (int i = 0; i < 9; i++) acc(32, 'hB000 + i, 1'b1);
        acc(32, 'hB000, 1'b1);  // evicted: miss
        acc(32, 'hB002, 1'b1);  // position 7
        acc(32, 'hB001, 1'b1);  // evicted: miss
        pulse();
        chk_snap('{0,0,0,0,0,0,0,1}, "R4 evict");
    endtask

    // R2: unsampled sets neither count nor disturb sampled rows.
    task automatic t_unsampled();
        acc(1, 'hA002, 1'b1);
        acc(1, 'hA002, 1'b1);
        acc(16, 'hA001, 1'b1);
        acc(16, 'hA001, 1'b1);
        pulse();
        chk_snap('{0,0,0,0,0,0,0,0}, "R2 unsampled");
        acc(0, 'hA002, 1'b1);   // still least recent in set 0
        pulse();
        chk_snap('{0,0,0,0,0,0,0,1}, "R2 row untouched");
    endtask

    // R6: owner-served hit reorders but does not count.
    task automatic t_owner();
        acc(0, 'hA003, 1'b0);   // position 7, not counted
        pulse();
        chk_snap('{0,0,0,0,0,0,0,0}, "R6 owner");
        acc(0, 'hA004, 1'b1);   // now position 7 after the reorder
        pulse();
        chk_snap('{0,0,0,0,0,0,0,1}, "R6 reorder");
    endtask

    // R7/R8: saturation and snapshot hold.
    task automatic t_saturate();
        acc(64, 'hC000, 1'b1);
        for (int i = 0; i < 40; i++) acc(64, 'hC000, 1'b1);
        rd_pos = 3'd7;
        #1;
        check("R8 snapshot hold", int'(rd_count), 1);
        pulse();
        chk_snap('{31,0,0,0,0,0,0,0}, "R7 saturate");
        chk_est(8, 31);
    endtask

    // R8: a hit in the period-end cycle counts in the new period.
    task automatic t_edge();
        acc_valid = 1'b1; acc_set = '0; acc_tag = 'hA004; acc_needs_data = 1'b1;
        period_end = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; period_end = 1'b0;
        chk_snap('{0,0,0,0,0,0,0,0}, "R8 edge old");
        pulse();
        chk_snap('{1,0,0,0,0,0,0,0}, "R8 edge new");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_recency();
        t_evict();
        t_unsampled();
        t_owner();
        t_saturate();
        t_edge();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: all R, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule